// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the transaction layer of an SMBus target. It sits on top of a byte-level target engine that already handles bit timing and address matching. That engine sends the responder one-cycle event pulses: a start (or repeated start), an address match carrying the read/write bit, each received byte, each request for a byte to transmit, the controller's acknowledge after a transmitted byte, and a stop. For every received byte, the responder gives an acknowledge decision in the same cycle. It also keeps the byte to transmit present on its output.

The responder holds a command register and a set of 16-bit word registers. It also has a process-call operand and a block buffer of up to 32 bytes with a stored length. Bus transactions read and write these. A host-side port writes and reads the word registers directly.

Command codes:
- `0 .. NREG-1` select a word register.
- `BLK_CMD` (default 0x20) selects the block buffer.
- `PC_CMD` (default 0x30) selects the process-call operand.
- Any other code is unmapped.

Top module: `smbr_top`

## Requirements
- R1: After reset the command register is 0, every word register, the operand, the block length and the block bytes are 0, `txDrive` is 0, and `rxAck` is 0.
- R2: After an address match with write (`addrRw`=0), the first received byte is always acknowledged and loaded as the command. The command is kept across transactions. A write that stops after the command alone changes no register contents.
- R3: After an address match with read, `txDrive` becomes 1. A bare read (no command phase) returns the low byte of the register selected by the most recent command.
- R4: A word-register read returns the low byte first, then the high byte. Any further byte reads as 0xFF.
- R5: After the command of a word register, byte 1 writes the low half and byte 2 writes the high half, each acknowledged. Further bytes are NACKed and do not change the register. A write of one data byte leaves the high half unchanged.
- R6: Under `PC_CMD`, bytes 1 and 2 set the operand (low, then high). The read that follows returns the bitwise inverse of the operand, low byte first.
- R7: A read under `BLK_CMD` returns the stored length first, then that many stored bytes in order, then 0xFF.
- R8: Under `BLK_CMD`, byte 1 is a count. A count up to 32 is acknowledged, becomes the stored length, and the next `count` bytes fill the buffer from index 0. A count above 32, and any data byte beyond the count, is NACKed and writes nothing.
- R9: When the controller NACKs a transmitted byte, `txDrive` falls and stays 0 until the next start or stop. Start and stop also clear `txDrive`.
- R10: The host port writes and reads word registers by index. If a host write and a bus write hit the same register in the same cycle, the bus write takes effect and the host write is dropped.
- R11: `rxAck` is 1 only in a cycle with a received-byte pulse. Bytes received while addressed for read, or under an unmapped command beyond the command byte, are NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evStart | input | 1 | Start or repeated-start pulse |
| evStop | input | 1 | Stop pulse |
| evAddr | input | 1 | Own-address match pulse |
| addrRw | input | 1 | Read/write bit with `evAddr` (1 = read) |
| evRxByte | input | 1 | Received-byte pulse |
| rxData | input | 8 | Received byte |
| rxAck | output | 1 | Acknowledge decision for the byte in this cycle |
| evTxReq | input | 1 | Pulse: the current `txData` byte was sent |
| txData | output | 8 | Byte to transmit next |
| txDrive | output | 1 | Responder is supplying read data |
| evCtrlAck | input | 1 | Controller acknowledge-phase pulse after a transmitted byte |
| ctrlAck | input | 1 | Controller bit with `evCtrlAck` (1 = ACK) |
| hostWe | input | 1 | Host write strobe |
| hostIdx | input | 2 | Host register index |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Register at `hostIdx` |

## Verification
A host write and a bus data byte can reach the same word register in the same clock cycle. The bench provokes this by raising `hostWe` for register 0 in the same cycle as the received low byte of a bus write to register 0. It then judges the outcome through `hostRdata`: the low half must carry the bus byte and the high half must keep its old value, because the host word is dropped. A checker property also requires `hostRdata` to hold steady whenever neither writer is active.

// File: rtl/smbr_pkg.sv
package smbr_pkg;
  localparam int BLK_DEPTH = 32;
  localparam int BIDX_W = $clog2(BLK_DEPTH);
  localparam int LEN_W = $clog2(BLK_DEPTH + 1);
  localparam int CNT_W = 7;

  typedef struct packed {
    logic cmdLd;
    logic wrLo;
    logic wrHi;
    logic pcLo;
    logic pcHi;
    logic cntLd;
    logic blkWr;
    logic [BIDX_W-1:0] blkIdx;
    logic [7:0] byteVal;
  } strobe_t;
endpackage

// File: rtl/smbr_ctrl.sv
module smbr_ctrl
  import smbr_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [7:0] BLK_CMD = 8'h20,
  parameter logic [7:0] PC_CMD = 8'h30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evStart,
  input  logic             evStop,
  input  logic             evAddr,
  input  logic             addrRw,
  input  logic             evRxByte,
  input  logic [7:0]       rxData,
  input  logic             evTxReq,
  input  logic             evCtrlAck,
  input  logic             ctrlAck,
  input  logic [LEN_W-1:0] blkLen,
  output logic             rxAck,
  output logic             txDrive,
  output logic [CNT_W-1:0] txPtr,
  output logic [7:0]       cmd,
  output strobe_t          stb
);
  logic wrPhase, cntOk;
  logic [CNT_W-1:0] rxIdx, dataIdx;
  logic isWord, isBlk, isPc;

  assign isWord = cmd < 8'(NREG);
  assign isBlk = cmd == BLK_CMD;
  assign isPc = cmd == PC_CMD;
  assign dataIdx = rxIdx - CNT_W'(2);

  always_comb begin
    stb = '0;
    stb.byteVal = rxData;
    stb.blkIdx = dataIdx[BIDX_W-1:0];
    rxAck = 1'b0;
    if (evRxByte && wrPhase) begin
      if (rxIdx == '0) begin
        rxAck = 1'b1;
        stb.cmdLd = 1'b1;
      end else if (isWord || isPc) begin
        if (rxIdx == CNT_W'(1)) begin
          rxAck = 1'b1;
          stb.wrLo = isWord;
          stb.pcLo = isPc;
        end else if (rxIdx == CNT_W'(2)) begin
          rxAck = 1'b1;
          stb.wrHi = isWord;
          stb.pcHi = isPc;
        end
      end else if (isBlk) begin
        if (rxIdx == CNT_W'(1)) begin
          rxAck = rxData <= 8'(BLK_DEPTH);
          stb.cntLd = rxAck;
        end else if (cntOk && (dataIdx < CNT_W'(blkLen))) begin
          rxAck = 1'b1;
          stb.blkWr = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPhase <= 1'b0;
      cntOk <= 1'b0;
      rxIdx <= '0;
      txDrive <= 1'b0;
      txPtr <= '0;
      cmd <= '0;
    end else if (evStart || evStop) begin
      wrPhase <= 1'b0;
      cntOk <= 1'b0;
      rxIdx <= '0;
      txDrive <= 1'b0;
    end else if (evAddr) begin
      wrPhase <= !addrRw;
      cntOk <= 1'b0;
      rxIdx <= '0;
      txDrive <= addrRw;
      txPtr <= '0;
    end else begin
      if (evRxByte && wrPhase && rxIdx != '1) rxIdx <= rxIdx + CNT_W'(1);
      if (stb.cmdLd) cmd <= rxData;
      if (stb.cntLd) cntOk <= 1'b1;
      if (evTxReq && txDrive && txPtr != '1) txPtr <= txPtr + CNT_W'(1);
      if (evCtrlAck && !ctrlAck) txDrive <= 1'b0;
    end
  end
endmodule

// File: rtl/smbr_dpath.sv
module smbr_dpath
  import smbr_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [7:0] BLK_CMD = 8'h20,
  parameter logic [7:0] PC_CMD = 8'h30,
  localparam int IDXR = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [7:0]       cmd,
  input  logic [CNT_W-1:0] txPtr,
  input  logic             hostWe,
  input  logic [IDXR-1:0]  hostIdx,
  input  logic [15:0]      hostWdata,
  output logic [15:0]      hostRdata,
  output logic [LEN_W-1:0] blkLen,
  output logic [7:0]       txData
);
  logic [15:0] regs [NREG];
  logic [15:0] pcWord;
  logic [7:0] blkBuf [BLK_DEPTH];
  logic [IDXR-1:0] regSel;
  logic [CNT_W-1:0] rdIdx;
  logic hostLost;

  assign regSel = cmd[IDXR-1:0];
  assign rdIdx = txPtr - CNT_W'(1);
  assign hostLost = (stb.wrLo || stb.wrHi) && (regSel == hostIdx);
  assign hostRdata = regs[hostIdx];

  for (genvar g = 0; g < NREG; g++) begin : gReg
    always_ff @(posedge clk) begin
      if (!rstN) regs[g] <= '0;
      else if (regSel == IDXR'(g) && stb.wrLo) regs[g][7:0] <= stb.byteVal;
      else if (regSel == IDXR'(g) && stb.wrHi) regs[g][15:8] <= stb.byteVal;
      else if (hostWe && !hostLost && hostIdx == IDXR'(g)) regs[g] <= hostWdata;
    end
  end

  for (genvar g = 0; g < BLK_DEPTH; g++) begin : gBlk
    always_ff @(posedge clk) begin
      if (!rstN) blkBuf[g] <= '0;
      else if (stb.blkWr && stb.blkIdx == BIDX_W'(g)) blkBuf[g] <= stb.byteVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcWord <= '0;
      blkLen <= '0;
    end else begin
      if (stb.pcLo) pcWord[7:0] <= stb.byteVal;
      if (stb.pcHi) pcWord[15:8] <= stb.byteVal;
      if (stb.cntLd) blkLen <= stb.byteVal[LEN_W-1:0];
    end
  end

  always_comb begin
    txData = 8'hFF;
    if (cmd < 8'(NREG)) begin
      if (txPtr == '0) txData = regs[regSel][7:0];
      else if (txPtr == CNT_W'(1)) txData = regs[regSel][15:8];
    end else if (cmd == PC_CMD) begin
      if (txPtr == '0) txData = ~pcWord[7:0];
      else if (txPtr == CNT_W'(1)) txData = ~pcWord[15:8];
    end else if (cmd == BLK_CMD) begin
      if (txPtr == '0) txData = 8'(blkLen);
      else if (txPtr <= CNT_W'(blkLen)) txData = blkBuf[rdIdx[BIDX_W-1:0]];
    end
  end
endmodule

// File: rtl/smbr_top.sv
module smbr_top
  import smbr_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [7:0] BLK_CMD = 8'h20,
  parameter logic [7:0] PC_CMD = 8'h30,
  localparam int IDXR = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evStart,
  input  logic            evStop,
  input  logic            evAddr,
  input  logic            addrRw,
  input  logic            evRxByte,
  input  logic [7:0]      rxData,
  output logic            rxAck,
  input  logic            evTxReq,
  output logic [7:0]      txData,
  output logic            txDrive,
  input  logic            evCtrlAck,
  input  logic            ctrlAck,
  input  logic            hostWe,
  input  logic [IDXR-1:0] hostIdx,
  input  logic [15:0]     hostWdata,
  output logic [15:0]     hostRdata
);
  strobe_t stb;
  logic [7:0] cmd;
  logic [CNT_W-1:0] txPtr;
  logic [LEN_W-1:0] blkLen;

  smbr_ctrl #(.NREG(NREG), .BLK_CMD(BLK_CMD), .PC_CMD(PC_CMD)) ctrl_i (
    .clk, .rstN, .evStart, .evStop, .evAddr, .addrRw, .evRxByte, .rxData,
    .evTxReq, .evCtrlAck, .ctrlAck, .blkLen, .rxAck, .txDrive, .txPtr,
    .cmd, .stb
  );

  smbr_dpath #(.NREG(NREG), .BLK_CMD(BLK_CMD), .PC_CMD(PC_CMD)) dpath_i (
    .clk, .rstN, .stb, .cmd, .txPtr, .hostWe, .hostIdx, .hostWdata,
    .hostRdata, .blkLen, .txData
  );
endmodule

// File: rtl/smbr_chk.sv
module smbr_chk #(
  parameter int IDXR = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            evStart,
  input logic            evStop,
  input logic            evAddr,
  input logic            addrRw,
  input logic            evRxByte,
  input logic            rxAck,
  input logic            txDrive,
  input logic            evCtrlAck,
  input logic            ctrlAck,
  input logic            hostWe,
  input logic [IDXR-1:0] hostIdx,
  input logic [15:0]     hostRdata
);
  // R9
  nack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evCtrlAck && !ctrlAck) |=> !txDrive);

  // R9
  bound_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evStart || evStop) |=> !txDrive);

  // R3
  read_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evAddr && addrRw && !evStart && !evStop) |=> txDrive);

  // R11
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evRxByte |-> !rxAck);

  // R10
  host_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWe && !evRxByte) |=> (!$stable(hostIdx) || $stable(hostRdata)));
endmodule

bind smbr_top smbr_chk #(.IDXR(IDXR)) chk_i (
  .clk, .rstN, .evStart, .evStop, .evAddr, .addrRw, .evRxByte, .rxAck,
  .txDrive, .evCtrlAck, .ctrlAck, .hostWe, .hostIdx, .hostRdata
);

// File: tb/smbr_top_tb_top.sv
module smbr_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart = 0, evStop = 0, evAddr = 0, addrRw = 0, evRxByte = 0;
  logic [7:0] rxData = '0;
  logic rxAck, txDrive;
  logic evTxReq = 0, evCtrlAck = 0, ctrlAck = 0, hostWe = 0;
  logic [7:0] txData;
  logic [1:0] hostIdx = '0;
  logic [15:0] hostWdata = '0, hostRdata;
  int nRun = 0, nFail = 0;
  logic ak;
  logic [7:0] b;

  always #5 clk = ~clk;

  smbr_top dut_i (.*);

  localparam logic [23:0] VEC [4] = '{24'h00A1B2, 24'h010C3D, 24'h02F00F, 24'h038421};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
  endtask

  task automatic addr(input logic rw);
    @(negedge clk) begin evAddr = 1; addrRw = rw; end
    @(negedge clk) evAddr = 0;
  endtask

  task automatic rxb(input logic [7:0] d, output logic a);
    @(negedge clk) begin evRxByte = 1; rxData = d; end
    #1 a = rxAck;
    @(negedge clk) evRxByte = 0;
  endtask

  task automatic txb(input logic a, output logic [7:0] d);
    @(negedge clk) begin d = txData; evTxReq = 1; end
    @(negedge clk) begin evTxReq = 0; evCtrlAck = 1; ctrlAck = a; end
    @(negedge clk) evCtrlAck = 0;
  endtask

  task automatic hwr(input logic [1:0] i, input logic [15:0] d);
    @(negedge clk) begin hostWe = 1; hostIdx = i; hostWdata = d; end
    @(negedge clk) hostWe = 0;
  endtask

  task automatic hrd(input logic [1:0] i, output logic [15:0] d);
    @(negedge clk) hostIdx = i;
    #1 d = hostRdata;
  endtask

  task automatic cmdOnly(input logic [7:0] c);
    logic a;
    pulse(evStart); addr(0); rxb(c, a); pulse(evStop);
  endtask

  initial begin
    #2000000;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    hrd(0, w); chk("R1 reg0", w, 16'h0);
    chk("R1 txDrive", {15'b0, txDrive}, 16'h0);
    chk("R1 rxAck", {15'b0, rxAck}, 16'h0);

    for (int i = 0; i < 4; i++) hwr(VEC[i][17:16], VEC[i][15:0]);
    // R3 R4 table: command then bare read
    for (int i = 0; i < 4; i++) begin
      logic [7:0] lo, hi;
      cmdOnly(VEC[i][23:16]);
      pulse(evStart); addr(1);
      txb(1, lo); txb(0, hi); pulse(evStop);
      chk("R3 low byte", {8'h0, lo}, {8'h0, VEC[i][7:0]});
      chk("R4 high byte", {8'h0, hi}, {8'h0, VEC[i][15:8]});
    end
    // R2 command-only write left contents intact
    hrd(3, w); chk("R2 no content change", w, 16'h8421);
    pulse(evStart); addr(0); rxb(8'h02, ak); pulse(evStop);
    chk("R2 cmd ack", {15'b0, ak}, 16'h1);
    pulse(evStart); addr(1); txb(1, b);
    chk("R2 cmd kept", {8'h0, b}, 16'h000F);
    txb(1, b); txb(0, b);
    chk("R4 beyond word", {8'h0, b}, 16'h00FF);
    pulse(evStop);

    // R5 write word, extra byte
    pulse(evStart); addr(0); rxb(8'h01, ak); rxb(8'h34, ak);
    chk("R5 low ack", {15'b0, ak}, 16'h1);
    rxb(8'h12, ak); chk("R5 high ack", {15'b0, ak}, 16'h1);
    rxb(8'h99, ak); chk("R5 extra nack", {15'b0, ak}, 16'h0);
    pulse(evStop);
    hrd(1, w); chk("R5 word", w, 16'h1234);
    cmdOnly(8'h02);
    pulse(evStart); addr(0); rxb(8'h02, ak); rxb(8'h77, ak); pulse(evStop);
    hrd(2, w); chk("R5 byte write", w, 16'hF077);

    // R6 process call
    pulse(evStart); addr(0); rxb(8'h30, ak); rxb(8'hA5, ak); rxb(8'h5A, ak);
    pulse(evStart); addr(1);
    txb(1, b); chk("R6 low", {8'h0, b}, 16'h005A);
    txb(0, b); chk("R6 high", {8'h0, b}, 16'h00A5);
    pulse(evStop);

    // R8 block write
    pulse(evStart); addr(0); rxb(8'h20, ak); rxb(8'h03, ak);
    chk("R8 count ack", {15'b0, ak}, 16'h1);
    rxb(8'h11, ak); rxb(8'h22, ak); rxb(8'h33, ak);
    chk("R8 data ack", {15'b0, ak}, 16'h1);
    rxb(8'h44, ak); chk("R8 over count nack", {15'b0, ak}, 16'h0);
    pulse(evStop);
    // R7 block read
    pulse(evStart); addr(0); rxb(8'h20, ak);
    pulse(evStart); addr(1);
    txb(1, b); chk("R7 count", {8'h0, b}, 16'h0003);
    txb(1, b); chk("R7 d0", {8'h0, b}, 16'h0011);
    txb(1, b); chk("R7 d1", {8'h0, b}, 16'h0022);
    txb(1, b); chk("R7 d2", {8'h0, b}, 16'h0033);
    txb(0, b); chk("R7 past end", {8'h0, b}, 16'h00FF);
    pulse(evStop);
    // R8 count above limit
    pulse(evStart); addr(0); rxb(8'h20, ak); rxb(8'd33, ak);
    chk("R8 big count nack", {15'b0, ak}, 16'h0);
    rxb(8'hEE, ak); chk("R8 data after bad count", {15'b0, ak}, 16'h0);
    pulse(evStop);
    pulse(evStart); addr(1);
    txb(1, b); chk("R8 len kept", {8'h0, b}, 16'h0003);
    txb(0, b); chk("R8 data kept", {8'h0, b}, 16'h0011);

    // R9 release after NACK
    #1 chk("R9 released", {15'b0, txDrive}, 16'h0);
    txb(1, b);
    #1 chk("R9 stays released", {15'b0, txDrive}, 16'h0);
    // R11 bytes in read phase
    rxb(8'h55, ak); chk("R11 read phase nack", {15'b0, ak}, 16'h0);
    pulse(evStop);
    pulse(evStart); addr(0); rxb(8'h40, ak); rxb(8'h01, ak);
    chk("R11 unmapped nack", {15'b0, ak}, 16'h0);
    pulse(evStop);

    // R10 collision: bus low byte and host word same cycle on reg0
    pulse(evStart); addr(0); rxb(8'h00, ak);
    @(negedge clk) begin
      evRxByte = 1; rxData = 8'h55;
      hostWe = 1; hostIdx = 0; hostWdata = 16'hBEEF;
    end
    @(negedge clk) begin evRxByte = 0; hostWe = 0; end
    pulse(evStop);
    hrd(0, w); chk("R10 bus wins", w, 16'hA155);
    hwr(3, 16'h0BAD); hrd(3, w); chk("R10 host write", w, 16'h0BAD);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule